// File: doc/BRIEF.md
# Parking Lot Occupancy Tracker

This block keeps a running tally of the vehicles inside a lot. It takes two presence detectors, one at the gate in and one at the gate out. A detector holds its output high for as long as a vehicle stands in front of it, so a high period can last any number of cycles. Each detector is brought into the clock domain through a flop chain. The leading edge of its synchronised level becomes one arrival or departure event.

Each event moves the tally up or down by one. An arrival while the lot is at capacity is refused, and so is a departure while the lot is empty. A refused event leaves the tally where it is and produces a one-cycle error pulse, which is also held in a sticky flag. An arrival and a departure that land in the same cycle cancel and are always legal.

Single-cycle arrival and departure strobes come out together with the tally update, so that neighbouring logic can capture a time of day for each movement. Capacity and synchroniser depth are parameters.

Top module: `park_occupancy`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `occupancy` is 0, `lot_empty` is 1, and `lot_full`, `move_err`, `move_err_seen`, `entry_evt` and `exit_evt` are all 0.
- R2: A departure event while `occupancy` is 0 sets `move_err` for one cycle, sets `move_err_seen`, and leaves `occupancy` at 0.
- R3: An arrival event while `occupancy` equals MAX_OCC (default 1024) sets `move_err` for one cycle, sets `move_err_seen`, and leaves `occupancy` at MAX_OCC.
- R4: One continuous high period on a sensor input, whatever its length, produces exactly one event. With SYNC_STAGES = 2, the resulting outputs change on the second rising clock edge after the edge at which the input is first sampled high.
- R5: An arrival event and a departure event in the same cycle leave `occupancy` unchanged and raise no error. This also holds at 0 and at MAX_OCC.
- R6: `clr` high at a rising edge sets `occupancy` to 0 at that edge and suppresses any error from events in that cycle. `clr` does not clear `move_err_seen`.
- R7: `lot_full` is 1 exactly when `occupancy` equals MAX_OCC. `lot_empty` is 1 exactly when `occupancy` is 0.
- R8: `move_err` pulses for one cycle per refused event. `move_err_seen` rises in the same cycle as that pulse and stays 1 until `rst`.
- R9: `entry_evt` and `exit_evt` are one-cycle strobes issued in the cycle the tally updates. They are issued for every event, including refused ones and events in a `clr` cycle.
- R10: Without `clr`, a lone legal arrival adds one to `occupancy` and a lone legal departure subtracts one. `occupancy` never exceeds MAX_OCC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, clears all state |
| clr | input | 1 | Synchronous clear of the tally, active high |
| entry_sense | input | 1 | Entry gate detector level, high while a vehicle is present |
| exit_sense | input | 1 | Exit gate detector level, high while a vehicle is present |
| occupancy | output | CNT_W (11) | Vehicles currently inside |
| lot_full | output | 1 | Tally equals MAX_OCC |
| lot_empty | output | 1 | Tally equals 0 |
| move_err | output | 1 | One-cycle pulse on a refused move |
| move_err_seen | output | 1 | Sticky record of any refused move since reset |
| entry_evt | output | 1 | One-cycle arrival strobe |
| exit_evt | output | 1 | One-cycle departure strobe |

## Verification
Arrival and departure events can meet in one cycle. The bench provokes this by raising both detectors on the same clock, in the middle of the range, at an empty lot and at a full lot. It also lets randomly timed levels on the two detectors overlap freely. A clear can coincide with an event as well, and the bench drives a clear during an arrival. A behavioural reference model fed the same levels predicts the tally, flags and strobes, and it is compared with the ports on every clock.

// File: rtl/park_pkg.sv
package park_pkg;

   typedef enum logic [1:0] {
      MV_NONE = 2'd0,
      MV_IN   = 2'd1,
      MV_OUT  = 2'd2,
      MV_BOTH = 2'd3
   } move_e;

   function automatic move_e classify(input logic in_ev, input logic out_ev);
      move_e m;
      case ({out_ev, in_ev})
         2'b01:   m = MV_IN;
         2'b10:   m = MV_OUT;
         2'b11:   m = MV_BOTH;
         default: m = MV_NONE;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/park_edge.sv
module park_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic level_i,
   output logic rise_o
);

   // pipe[0..SYNC_STAGES-1] synchronise; pipe[SYNC_STAGES] holds the previous level
   logic [SYNC_STAGES:0] pipe;

   always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[SYNC_STAGES-1:0], level_i};
   end

   assign rise_o = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];

   // R4: one high period cannot yield two back-to-back events
   p_one_event_r4: assert property (@(posedge clk) disable iff (rst)
      rise_o |=> !rise_o);

endmodule

// File: rtl/park_counter.sv
module park_counter
   import park_pkg::*;
#(
   parameter int MAX_OCC = 1024,
   parameter int CNT_W   = $clog2(MAX_OCC + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] count_o,
   output logic             full_o,
   output logic             empty_o,
   output logic             err_o,
   output logic             err_sticky_o,
   output logic             in_evt_o,
   output logic             out_evt_o
);

   localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_OCC);

   move_e            mv;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic             err_nxt;

   assign mv = classify(inc, dec);

   always_comb begin
      cnt_nxt = cnt;
      err_nxt = 1'b0;
      case (mv)
         MV_IN: begin
            if (cnt == TOP) err_nxt = 1'b1;
            else            cnt_nxt = cnt + CNT_W'(1);
         end
         MV_OUT: begin
            if (cnt == '0) err_nxt = 1'b1;
            else           cnt_nxt = cnt - CNT_W'(1);
         end
         default: cnt_nxt = cnt;
      endcase
      if (clr) begin
         cnt_nxt = '0;
         err_nxt = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt          <= '0;
         err_o        <= 1'b0;
         err_sticky_o <= 1'b0;
         in_evt_o     <= 1'b0;
         out_evt_o    <= 1'b0;
      end else begin
         cnt          <= cnt_nxt;
         err_o        <= err_nxt;
         err_sticky_o <= err_sticky_o | err_nxt;
         in_evt_o     <= inc;
         out_evt_o    <= dec;
      end
   end

   assign count_o = cnt;
   assign full_o  = (cnt == TOP);
   assign empty_o = (cnt == '0);

   p_floor_r2: assert property (@(posedge clk) disable iff (rst)
      (!clr && mv == MV_OUT && cnt == '0) |=> (cnt == '0 && err_o));

   p_cap_r3: assert property (@(posedge clk) disable iff (rst)
      (!clr && mv == MV_IN && cnt == TOP) |=> (cnt == TOP && err_o));

   p_pair_r5: assert property (@(posedge clk) disable iff (rst)
      (!clr && mv == MV_BOTH) |=> ($stable(cnt) && !err_o));

   p_clear_r6: assert property (@(posedge clk) disable iff (rst)
      clr |=> (cnt == '0 && !err_o));

   p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      err_sticky_o |=> err_sticky_o);

   p_step_up_r10: assert property (@(posedge clk) disable iff (rst)
      (!clr && mv == MV_IN && cnt != TOP) |=> (cnt == $past(cnt) + CNT_W'(1)));

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
      cnt <= TOP);

endmodule

// File: rtl/park_occupancy.sv
module park_occupancy #(
   parameter int MAX_OCC     = 1024,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(MAX_OCC + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             entry_sense,
   input  logic             exit_sense,
   output logic [CNT_W-1:0] occupancy,
   output logic             lot_full,
   output logic             lot_empty,
   output logic             move_err,
   output logic             move_err_seen,
   output logic             entry_evt,
   output logic             exit_evt
);

   localparam int N_CHAN = 2;

   if (MAX_OCC < 1) begin : g_bad_cap
      $error("park_occupancy: MAX_OCC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("park_occupancy: SYNC_STAGES must be at least 2");
   end

   logic [N_CHAN-1:0] sense;
   logic [N_CHAN-1:0] rise;

   assign sense = {exit_sense, entry_sense};

   for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
      park_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk     (clk),
         .rst     (rst),
         .level_i (sense[ch]),
         .rise_o  (rise[ch])
      );
   end

   park_counter #(.MAX_OCC(MAX_OCC), .CNT_W(CNT_W)) u_count (
      .clk          (clk),
      .rst          (rst),
      .clr          (clr),
      .inc          (rise[0]),
      .dec          (rise[1]),
      .count_o      (occupancy),
      .full_o       (lot_full),
      .empty_o      (lot_empty),
      .err_o        (move_err),
      .err_sticky_o (move_err_seen),
      .in_evt_o     (entry_evt),
      .out_evt_o    (exit_evt)
   );

   // R7: the two status flags are never both raised
   p_flags_r7: assert property (@(posedge clk) disable iff (rst)
      !(lot_full && lot_empty));

endmodule

// File: tb/park_occupancy_test.sv
module park_occupancy_test;

   localparam int MAX  = 1024;
   localparam int SYNC = 2;
   localparam int CW   = $clog2(MAX + 1);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic clr = 1'b0;
   logic ent = 1'b0;
   logic ext = 1'b0;
   logic [CW-1:0] occupancy;
   logic lot_full, lot_empty, move_err, move_err_seen, entry_evt, exit_evt;

   int checks = 0;
   int failures = 0;
   bit started = 0;

   always #5 clk = ~clk;

   park_occupancy #(.MAX_OCC(MAX), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst(rst), .clr(clr),
      .entry_sense(ent), .exit_sense(ext),
      .occupancy(occupancy), .lot_full(lot_full), .lot_empty(lot_empty),
      .move_err(move_err), .move_err_seen(move_err_seen),
      .entry_evt(entry_evt), .exit_evt(exit_evt)
   );

   // behavioural reference model
   int m_cnt = 0;
   bit m_err = 0, m_seen = 0, m_ee = 0, m_xe = 0;
   bit he[$];
   bit hx[$];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   initial begin
      for (int i = 0; i <= SYNC; i++) begin he.push_back(0); hx.push_back(0); end
   end

   always @(posedge clk) begin
      bit re, rx;
      started = 1;
      if (rst) begin
         m_cnt = 0; m_err = 0; m_seen = 0; m_ee = 0; m_xe = 0;
         for (int i = 0; i <= SYNC; i++) begin he[i] = 0; hx[i] = 0; end
      end else begin
         re = he[SYNC-1] && !he[SYNC];
         rx = hx[SYNC-1] && !hx[SYNC];
         m_err = 0;
         m_ee = re;
         m_xe = rx;
         if (clr) m_cnt = 0;
         else if (re && !rx) begin
            if (m_cnt == MAX) m_err = 1; else m_cnt++;
         end else if (rx && !re) begin
            if (m_cnt == 0) m_err = 1; else m_cnt--;
         end
         m_seen = m_seen | m_err;
         void'(he.pop_back()); he.push_front(ent);
         void'(hx.pop_back()); hx.push_front(ext);
      end
   end

   always @(negedge clk) begin
      if (started) begin
         chk(int'(occupancy) == m_cnt, "R10 occupancy", int'(occupancy), m_cnt);
         chk(lot_full == (m_cnt == MAX), "R7 lot_full", lot_full, m_cnt == MAX);
         chk(lot_empty == (m_cnt == 0), "R7 lot_empty", lot_empty, m_cnt == 0);
         chk(move_err == m_err, "R8 move_err", move_err, m_err);
         chk(move_err_seen == m_seen, "R8 move_err_seen", move_err_seen, m_seen);
         chk(entry_evt == m_ee, "R9 entry_evt", entry_evt, m_ee);
         chk(exit_evt == m_xe, "R9 exit_evt", exit_evt, m_xe);
      end
   end

   task automatic drive(input bit e, input bit x, input int hi, input int lo);
      ent = e; ext = x;
      repeat (hi) @(negedge clk);
      ent = 0; ext = 0;
      repeat (lo) @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1;
      repeat (3) @(negedge clk);
      rst = 0;
   endtask

   initial begin
      int pulses;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(occupancy == 0 && lot_empty && !lot_full && !move_err && !move_err_seen
          && !entry_evt && !exit_evt, "R1 reset state", int'(occupancy), 0);
      rst = 0;
      @(negedge clk);
      chk(occupancy == 0 && lot_empty && !move_err_seen, "R1 after release", int'(occupancy), 0);

      // R2: departure from an empty lot
      drive(0, 1, 3, 5);
      chk(occupancy == 0 && move_err_seen, "R2 underflow hold", int'(occupancy), 0);
      do_reset();
      @(negedge clk);
      chk(!move_err_seen, "R8 sticky cleared by rst", move_err_seen, 0);

      // R4: exact latency: input sampled high at the next edge, outputs two edges later
      ent = 1;
      @(negedge clk);
      chk(!entry_evt && occupancy == 0, "R4 no early event", int'(occupancy), 0);
      @(negedge clk);
      chk(!entry_evt, "R4 no event after one edge", entry_evt, 0);
      @(negedge clk);
      chk(entry_evt && occupancy == 1, "R4 event after two edges", int'(occupancy), 1);
      repeat (7) @(negedge clk);
      ent = 0;
      repeat (4) @(negedge clk);
      chk(occupancy == 1, "R4 long level counts once", int'(occupancy), 1);

      // R4/R10: variable length arrivals
      for (int i = 0; i < 19; i++) drive(1, 0, 1 + $urandom % 6, 1 + $urandom % 3);
      repeat (4) @(negedge clk);
      chk(occupancy == 20, "R4 twenty arrivals", int'(occupancy), 20);

      // R5: simultaneous in mid range
      drive(1, 1, 4, 5);
      chk(occupancy == 20 && !move_err_seen, "R5 pair mid range", int'(occupancy), 20);

      for (int i = 0; i < 5; i++) drive(0, 1, 2, 2);
      repeat (4) @(negedge clk);
      chk(occupancy == 15, "R10 five departures", int'(occupancy), 15);

      // R6: clear coinciding with an arrival event
      ent = 1;
      @(negedge clk);
      @(negedge clk);
      clr = 1;
      @(negedge clk);
      clr = 0;
      chk(occupancy == 0 && entry_evt && !move_err, "R6 clear wins", int'(occupancy), 0);
      ent = 0;
      repeat (4) @(negedge clk);

      // R5: pair at empty
      drive(1, 1, 2, 5);
      chk(occupancy == 0 && !move_err_seen, "R5 pair at zero", int'(occupancy), 0);

      // R3: fill to capacity
      for (int i = 0; i < MAX; i++) drive(1, 0, 1, 1);
      repeat (4) @(negedge clk);
      chk(occupancy == MAX && lot_full, "R7 full at capacity", int'(occupancy), MAX);
      drive(1, 1, 3, 5);
      chk(occupancy == MAX && !move_err_seen, "R5 pair at capacity", int'(occupancy), MAX);
      drive(1, 0, 2, 5);
      chk(occupancy == MAX && move_err_seen, "R3 overflow hold", int'(occupancy), MAX);

      // R6: clear keeps the sticky flag
      clr = 1;
      @(negedge clk);
      clr = 0;
      chk(occupancy == 0 && move_err_seen, "R6 clear keeps sticky", int'(occupancy), 0);

      // random overlapping levels, judged by the model each clock
      for (int i = 0; i < 3000; i++) begin
         if ($urandom % 3 == 0) ent = ~ent;
         if ($urandom % 4 == 0) ext = ~ext;
         clr = ($urandom % 200 == 0);
         @(negedge clk);
      end
      ent = 0; ext = 0; clr = 0;
      repeat (5) @(negedge clk);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule